// File: doc/BRIEF.md
# Secondary Processor Wake-Up Sequencer

This block brings a sleeping secondary processor into execution by issuing a fixed series of inter-processor messages through the command register pair of a local interrupt controller. A single start request supplies the destination processor ID and the 32-bit address where the woken processor should begin running. From that request the block generates an INIT assert, an INIT deassert and then the STARTUP message twice, with a timed pause after each one.

Every message goes out as two register writes. First the high command word carries the destination ID, and then the low command word carries the message type. The block never writes while the controller reports that its previous message is still being delivered. The pauses are set in microseconds and converted to clock cycles with a cycles-per-microsecond parameter, so a bench or a fast platform can shorten the nominal 10 ms pause after the deassert. The caller sees only a start strobe, a busy level and a one-cycle done pulse.

Top module: `ipi_wake_seq`

## Requirements
- R1: While reset is held and after it is released with no start request, busy_o, done_o and cmd_wr_o are low, and cmd_addr_o and cmd_data_o are zero.
- R2: A start_i seen while idle is accepted at that clock edge, and busy_o is high from the next cycle. A start_i seen while busy_o is high is ignored: the sequence in flight keeps its destination, address, write count and timing.
- R3: Each message is a write to offset 0x310 with data {dest_id, 24'h0}, followed by a write to offset 0x300. When deliv_busy_i stays low, the 0x300 write comes in the cycle right after the 0x310 write.
- R4: The first 0x300 write carries 0x0000C500: INIT mode 0x500, with the level bit 15 and the assert bit 14 set.
- R5: The second 0x300 write carries 0x00008500: INIT with the level bit set and the assert bit clear.
- R6: The third and fourth 0x300 writes each carry 0x00000600 OR entry_addr_i[19:12], where the address bits sit in data bits 7:0.
- R7: After a 0x300 write in cycle t, and with deliv_busy_i low, the next 0x310 write falls in cycle t+D+1. D is CYC_PER_US times ASSERT_US after the first message, times DEASSERT_US after the second, and times SIPI_US after the third.
- R8: cmd_wr_o is never high in a cycle where deliv_busy_i is high. A pending write waits and is issued in the first cycle in which deliv_busy_i is low.
- R9: After the fourth 0x300 write in cycle t, done_o is high for exactly cycle t+D+1 (D = CYC_PER_US times SIPI_US), and busy_o is low in that cycle.
- R10: Each accepted request produces exactly eight writes and one done pulse.
- R11: A start_i sampled at the edge that ends the done_o cycle is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request strobe |
| dest_id_i | input | 8 | Destination processor ID |
| entry_addr_i | input | 32 | Entry address (bits 19:12 are sent in the STARTUP message) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| deliv_busy_i | input | 1 | Controller delivery-status busy (low command word bit 12) |
| cmd_wr_o | output | 1 | Command register write strobe |
| cmd_addr_o | output | 12 | Register offset of the write |
| cmd_data_o | output | 32 | Write data |

## Verification
Two functions can land in the same cycle. The first pair is the end of a sequence and a fresh request: the bench raises start_i right after it sees done_o, so the request is sampled at the edge that ends the pulse, and it expects busy_o one cycle later along with a full, correctly timed second sequence. The second pair is a write falling due while the controller reports it is busy: the bench holds deliv_busy_i high across the point where the next high-word write should go out, then confirms that no write appeared during the hold and that the write was issued in the very cycle deliv_busy_i dropped.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;

  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned STEP_W    = 2;
  localparam int unsigned OFS_W     = 12;
  localparam int unsigned WORD_W    = 32;

  localparam logic [OFS_W-1:0]  OFS_CMD_HI = 12'h310;
  localparam logic [OFS_W-1:0]  OFS_CMD_LO = 12'h300;

  localparam logic [WORD_W-1:0] MODE_INIT  = 32'h0000_0500;
  localparam logic [WORD_W-1:0] MODE_SIPI  = 32'h0000_0600;
  localparam logic [WORD_W-1:0] FLAG_LEVEL = 32'h0000_8000;
  localparam logic [WORD_W-1:0] FLAG_ASRT  = 32'h0000_4000;
endpackage

// File: rtl/ipi_cmd_word.sv
module ipi_cmd_word
  import ipi_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [7:0]        page_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    unique case (step_i)
      2'd0:    word_o = MODE_INIT | FLAG_LEVEL | FLAG_ASRT;
      2'd1:    word_o = MODE_INIT | FLAG_LEVEL;
      default: word_o = MODE_SIPI | {24'h0, page_i};
    endcase
  end
endmodule

// File: rtl/ipi_step_delay.sv
module ipi_step_delay
  import ipi_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 100,
  parameter int unsigned ASSERT_US   = 200,
  parameter int unsigned DEASSERT_US = 10000,
  parameter int unsigned SIPI_US     = 200,
  parameter int unsigned CNT_W       = 24
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int unsigned CYC_ASSERT   = CYC_PER_US * ASSERT_US;
  localparam int unsigned CYC_DEASSERT = CYC_PER_US * DEASSERT_US;
  localparam int unsigned CYC_SIPI     = CYC_PER_US * SIPI_US;

  localparam logic [CNT_W-1:0] RL_ASSERT   = CNT_W'(CYC_ASSERT - 1);
  localparam logic [CNT_W-1:0] RL_DEASSERT = CNT_W'(CYC_DEASSERT - 1);
  localparam logic [CNT_W-1:0] RL_SIPI     = CNT_W'(CYC_SIPI - 1);

  always_comb begin
    unique case (step_i)
      2'd0:    reload_o = RL_ASSERT;
      2'd1:    reload_o = RL_DEASSERT;
      default: reload_o = RL_SIPI;
    endcase
  end
endmodule

// File: rtl/ipi_down_timer.sv
module ipi_down_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_en = load_i | (run_i & ~zero_o);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ipi_wake_seq.sv
module ipi_wake_seq
  import ipi_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 100,
  parameter int unsigned ASSERT_US   = 200,
  parameter int unsigned DEASSERT_US = 10000,
  parameter int unsigned SIPI_US     = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  dest_id_i,
  input  logic [31:0] entry_addr_i,
  output logic        busy_o,
  output logic        done_o,
  input  logic        deliv_busy_i,
  output logic        cmd_wr_o,
  output logic [11:0] cmd_addr_o,
  output logic [31:0] cmd_data_o
);
  localparam int unsigned MAX_US_A = (ASSERT_US > SIPI_US) ? ASSERT_US : SIPI_US;
  localparam int unsigned MAX_US   = (DEASSERT_US > MAX_US_A) ? DEASSERT_US : MAX_US_A;
  localparam int unsigned CNT_W    = $clog2(CYC_PER_US * MAX_US + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [7:0]        dest_q;
  logic [7:0]        page_q;
  logic              done_q, done_d;
  logic              cap_en, step_en, tmr_load, tmr_zero, can_wr;
  logic [CNT_W-1:0]  reload;
  logic [WORD_W-1:0] lo_word;

  ipi_cmd_word u_word (
    .step_i (step_q),
    .page_i (page_q),
    .word_o (lo_word)
  );

  ipi_step_delay #(
    .CYC_PER_US  (CYC_PER_US),
    .ASSERT_US   (ASSERT_US),
    .DEASSERT_US (DEASSERT_US),
    .SIPI_US     (SIPI_US),
    .CNT_W       (CNT_W)
  ) u_dly (
    .step_i   (step_q),
    .reload_o (reload)
  );

  ipi_down_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (reload),
    .run_i      (state_q == ST_WAIT),
    .zero_o     (tmr_zero)
  );

  assign can_wr = ~deliv_busy_i;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    step_en  = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cap_en  = 1'b1;
        step_en = 1'b1;
        step_d  = '0;
        state_d = ST_HI;
      end
      ST_HI:   if (can_wr) state_d = ST_LO;
      ST_LO:   if (can_wr) begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: if (tmr_zero) begin
        if (step_q == LAST_STEP) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step_en = 1'b1;
          step_d  = step_q + 1'b1;
          state_d = ST_HI;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      page_q <= '0;
    end else if (cap_en) begin
      dest_q <= dest_id_i;
      page_q <= entry_addr_i[19:12];
    end
  end

  always_comb begin
    cmd_wr_o   = ((state_q == ST_HI) || (state_q == ST_LO)) && can_wr;
    cmd_addr_o = '0;
    cmd_data_o = '0;
    if (cmd_wr_o) begin
      if (state_q == ST_HI) begin
        cmd_addr_o = OFS_CMD_HI;
        cmd_data_o = {dest_q, 24'h0};
      end else begin
        cmd_addr_o = OFS_CMD_LO;
        cmd_data_o = lo_word;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/ipi_wake_seq_chk.sv
module ipi_wake_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        deliv_busy_i,
  input logic        cmd_wr_o,
  input logic [11:0] cmd_addr_o,
  input logic [31:0] cmd_data_o
);
  logic last_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_hi_q <= 1'b0;
    else if (cmd_wr_o) last_hi_q <= (cmd_addr_o == 12'h310);
  end

  p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_o |-> !deliv_busy_i);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cmd_wr_o && cmd_addr_o == 12'h0 && cmd_data_o == 32'h0));

  p_hi_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && cmd_addr_o == 12'h310) |-> (cmd_data_o[23:0] == 24'h0 && !last_hi_q));

  p_lo_after_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && cmd_addr_o == 12'h300) |-> last_hi_q);

  p_busy_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !done_o);
endmodule

bind ipi_wake_seq ipi_wake_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .deliv_busy_i (deliv_busy_i),
  .cmd_wr_o     (cmd_wr_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_data_o   (cmd_data_o)
);

// File: tb/test_ipi_wake_seq.sv
module test_ipi_wake_seq;
  localparam int CPU = 2, A_US = 3, DE_US = 5, S_US = 4;
  localparam int D0 = CPU * A_US, D1 = CPU * DE_US, D2 = CPU * S_US;

  logic        clk, rst_n, start_i, deliv_busy_i;
  logic [7:0]  dest_id_i;
  logic [31:0] entry_addr_i;
  logic        busy_o, done_o, cmd_wr_o;
  logic [11:0] cmd_addr_o;
  logic [31:0] cmd_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nw = 0, nd = 0, viol = 0;
  logic [11:0] la [0:127];
  logic [31:0] ld [0:127];
  int          lc [0:127];
  int          dc [0:31];

  ipi_wake_seq #(.CYC_PER_US(CPU), .ASSERT_US(A_US), .DEASSERT_US(DE_US), .SIPI_US(S_US))
  i_ipi_wake_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dest_id_i(dest_id_i),
    .entry_addr_i(entry_addr_i), .busy_o(busy_o), .done_o(done_o),
    .deliv_busy_i(deliv_busy_i), .cmd_wr_o(cmd_wr_o), .cmd_addr_o(cmd_addr_o),
    .cmd_data_o(cmd_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cmd_wr_o) begin
      if (nw < 128) begin la[nw] = cmd_addr_o; ld[nw] = cmd_data_o; lc[nw] = cyc; end
      nw++;
      if (deliv_busy_i) viol++;
    end
    if (done_o) begin
      if (nd < 32) dc[nd] = cyc;
      nd++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic do_start(input logic [7:0] d, input logic [31:0] a);
    @(posedge clk); #1;
    start_i = 1'b1; dest_id_i = d; entry_addr_i = a;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int n0);
    for (int i = 0; i < 5000 && nd <= n0; i++) @(negedge clk);
  endtask

  task automatic check_seq(input int b, input int di, input logic [7:0] d,
                           input logic [31:0] a, input bit timed);
    logic [31:0] exp_lo;
    int dl;
    for (int k = 0; k < 4; k++) begin
      chk(la[b+2*k] == 12'h310, "R3", "hi offset", 32'(la[b+2*k]), 32'h310);
      chk(ld[b+2*k] == {d, 24'h0}, "R3", "hi data", ld[b+2*k], {d, 24'h0});
      chk(la[b+2*k+1] == 12'h300, "R3", "lo offset", 32'(la[b+2*k+1]), 32'h300);
      exp_lo = (k == 0) ? 32'h0000C500 : (k == 1) ? 32'h00008500 : (32'h600 | 32'(a[19:12]));
      chk(ld[b+2*k+1] == exp_lo, (k == 0) ? "R4" : (k == 1) ? "R5" : "R6", "lo data",
          ld[b+2*k+1], exp_lo);
      if (timed) begin
        chk(lc[b+2*k+1] == lc[b+2*k] + 1, "R3", "lo follows hi",
            32'(lc[b+2*k+1]), 32'(lc[b+2*k] + 1));
        if (k > 0) begin
          dl = (k == 1) ? D0 : (k == 2) ? D1 : D2;
          chk(lc[b+2*k] == lc[b+2*k-1] + dl + 1, "R7", "gap before hi",
              32'(lc[b+2*k]), 32'(lc[b+2*k-1] + dl + 1));
        end
      end
    end
    chk(dc[di] == lc[b+7] + D2 + 1, "R9", "done cycle", 32'(dc[di]), 32'(lc[b+7] + D2 + 1));
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !cmd_wr_o, "R1", "ctl outs", {busy_o, done_o, cmd_wr_o}, 0);
    chk(cmd_addr_o == 0 && cmd_data_o == 0, "R1", "cmd bus", cmd_data_o, 0);
  endtask

  task automatic t_basic(input logic [7:0] d, input logic [31:0] a);
    int b = nw, n0 = nd;
    do_start(d, a);
    @(negedge clk);
    chk(busy_o, "R2", "busy after accept", 32'(busy_o), 1);
    wait_done(n0);
    chk(!busy_o, "R9", "busy in done cycle", 32'(busy_o), 0);
    @(negedge clk);
    chk(!done_o, "R9", "done width", 32'(done_o), 0);
    chk(nw == b + 8, "R10", "write count", 32'(nw - b), 8);
    chk(nd == n0 + 1, "R10", "done count", 32'(nd - n0), 1);
    check_seq(b, n0, d, a, 1'b1);
  endtask

  task automatic t_ignore;
    int b = nw, n0 = nd;
    do_start(8'h3C, 32'h000A_5000);
    for (int i = 0; i < 200 && nw < b + 3; i++) @(negedge clk);
    do_start(8'h11, 32'hABCD_E000);
    wait_done(n0);
    repeat (D2 + 6) @(negedge clk);
    chk(nw == b + 8, "R2", "writes with start while busy", 32'(nw - b), 8);
    chk(nd == n0 + 1, "R2", "dones with start while busy", 32'(nd - n0), 1);
    check_seq(b, n0, 8'h3C, 32'h000A_5000, 1'b1);
  endtask

  task automatic t_stall;
    int b = nw, n0 = nd, rc;
    do_start(8'h77, 32'h0012_3000);
    for (int i = 0; i < 200 && nw < b + 2; i++) @(negedge clk);
    deliv_busy_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(nw == b + 2, "R8", "no write while busy", 32'(nw - b), 2);
    @(posedge clk); #1;
    deliv_busy_i = 1'b0;
    rc = cyc;
    wait_done(n0);
    chk(lc[b+2] == rc, "R8", "write on release", 32'(lc[b+2]), 32'(rc));
    chk(viol == 0, "R8", "writes during busy", 32'(viol), 0);
    chk(nw == b + 8, "R10", "write count after stall", 32'(nw - b), 8);
    check_seq(b, n0, 8'h77, 32'h0012_3000, 1'b0);
  endtask

  task automatic t_back_to_back;
    int b, n0 = nd;
    do_start(8'h01, 32'h0000_1000);
    wait_done(n0);
    b = nw;
    start_i = 1'b1; dest_id_i = 8'hA5; entry_addr_i = 32'h0005_5000;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    chk(busy_o, "R11", "start in done cycle accepted", 32'(busy_o), 1);
    wait_done(n0 + 1);
    chk(nw == b + 8, "R11", "second run writes", 32'(nw - b), 8);
    check_seq(b, n0 + 1, 8'hA5, 32'h0005_5000, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; deliv_busy_i = 1'b0;
    dest_id_i = '0; entry_addr_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic(8'h5A, 32'h0009_F000);
    t_basic(8'hFF, 32'hFFFF_FFFF);
    t_ignore();
    t_stall();
    t_back_to_back();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule